// File: doc/BRIEF.md
# Serial Port Queue Interrupt Controller

This block holds the receive and transmit byte queues of a serial port and turns their fill levels, the receiver's error pulses and the modem-line activity into nine interrupt sources. Each source has a sticky raw bit, an enable bit and a masked status bit. Software enables sources through a simple register port and clears them by writing ones. The block also drives a hardware request-to-send stall when the receive queue passes a watermark. It runs an idle timer that flags received data left waiting too long without a new byte.

The bit-level shifters sit outside. The receiver pushes bytes and pulses its error lines. The transmitter pops bytes. A baud generator supplies one `bit_tick` pulse per bit period. The modem status lines `dsr_n` and `cts_n` are sampled as synchronous levels.

Top module: `sio_irq_ctrl`

## Requirements
- R1: Each queue holds up to DEPTH (default 16) bytes in arrival order. `rx_rdata`/`tx_rdata` show the oldest byte. A pop on an empty queue is ignored, and `*_level` gives the byte count.
- R2: `irq_status` is `irq_raw` masked bitwise by the enable vector. `irq` is high when any status bit is high. A register write with `reg_sel`=0 loads the enable vector from `reg_wdata`.
- R3: A register write with `reg_sel`=1 clears every raw bit whose `reg_wdata` bit is 1, in the cycle after the write. A source event in the same cycle as its clear leaves the raw bit set.
- R4: Raw bit 0 is set whenever the receive level is strictly greater than `rx_full_thr`.
- R5: Raw bit 1 is set whenever the transmit level is strictly less than `tx_empty_thr`.
- R6: One cycle after the receive level exceeds `rts_thr` while `rts_hw_en` is 1, `rts_n` goes high (stop sending). Otherwise `rts_n` is low.
- R7: A receive push while the receive queue holds DEPTH bytes is dropped and sets raw bit 4.
- R8: One-cycle pulses on `rx_parity_err`, `rx_frame_err` and `rx_break` set raw bits 2, 3 and 7 respectively, and no other bit.
- R9: Any edge, rising or falling, on `dsr_n` sets raw bit 5, and any edge on `cts_n` sets raw bit 6.
- R10: With `tout_en` set, raw bit 8 is set on the (`tout_thr`+1)th `bit_tick` after the last accepted receive byte while the receive queue is non-empty, once per idle spell. No ticks count while the queue is empty.
- R11: `rx_flush` and `tx_flush` empty their own queue only. A push in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receiver writes `rx_wdata` |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Consumer removes oldest receive byte |
| rx_rdata | output | 8 | Oldest receive byte |
| rx_level | output | LVL_W (5) | Receive byte count |
| rx_flush | input | 1 | Empty the receive queue |
| tx_push | input | 1 | Producer writes `tx_wdata` |
| tx_wdata | input | 8 | Byte to send |
| tx_pop | input | 1 | Transmitter removes oldest byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_level | output | LVL_W (5) | Transmit byte count |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_frame_err | input | 1 | Frame error pulse |
| rx_break | input | 1 | Break detect pulse |
| dsr_n | input | 1 | Data-set-ready line level |
| cts_n | input | 1 | Clear-to-send line level |
| bit_tick | input | 1 | One pulse per bit period |
| rx_full_thr | input | 7 | Receive fill threshold |
| tx_empty_thr | input | 7 | Transmit drain threshold |
| rts_thr | input | 7 | Receive watermark for RTS stall |
| rts_hw_en | input | 1 | Enable hardware RTS stall |
| tout_thr | input | 7 | Idle threshold in bit periods |
| tout_en | input | 1 | Enable idle interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: enable vector, 1: clear vector |
| reg_wdata | input | 9 | Register write data |
| irq_raw | output | 9 | Raw interrupt vector |
| irq_status | output | 9 | Masked interrupt vector |
| irq | output | 1 | Any masked interrupt pending |
| rts_n | output | 1 | High requests the far end to stop |

## Verification
The set of a raw bit and a write-one clear of the same bit can fall in one clock cycle. The bench drives a parity-error pulse and a clear write to bit 2 on the same falling edge, so both reach the register at the next rising edge. It then judges the raw bit one cycle later: it must still read 1. A clear alone, one cycle afterwards, must bring the bit to 0.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int unsigned NSRC  = 9;
  localparam int unsigned THR_W = 7;

  // Bit positions of the interrupt sources (software decodes these).
  localparam int unsigned IRQ_RXFULL  = 0;
  localparam int unsigned IRQ_TXEMPTY = 1;
  localparam int unsigned IRQ_PARITY  = 2;
  localparam int unsigned IRQ_FRAME   = 3;
  localparam int unsigned IRQ_OVF     = 4;
  localparam int unsigned IRQ_DSR     = 5;
  localparam int unsigned IRQ_CTS     = 6;
  localparam int unsigned IRQ_BREAK   = 7;
  localparam int unsigned IRQ_TOUT    = 8;

  typedef logic [NSRC-1:0] irq_vec_t;

  // Level strictly above a threshold.
  function automatic logic lvl_above(input logic [7:0] lvl, input logic [THR_W-1:0] thr);
    return lvl > {1'b0, thr};
  endfunction

  // Level strictly below a threshold.
  function automatic logic lvl_below(input logic [7:0] lvl, input logic [THR_W-1:0] thr);
    return lvl < {1'b0, thr};
  endfunction
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;
  logic          full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign level = count;
endmodule

// File: rtl/sio_idle_timer.sv
module sio_idle_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned THR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             idle_q,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic             cnt_max;

  assign cnt_max = (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart || idle_q)  cnt <= '0;
    else if (tick && !cnt_max)   cnt <= cnt + 1'b1;
  end

  assign fire = en && tick && !restart && !idle_q && (cnt == CNT_W'(thr));
endmodule

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
  import sio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t set_ev,
  input  irq_vec_t clr_vec,
  input  logic     ena_we,
  input  irq_vec_t ena_data,
  output irq_vec_t raw,
  output irq_vec_t ena
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
      ena <= '0;
    end else begin
      raw <= (raw & ~clr_vec) | set_ev;
      if (ena_we) ena <= ena_data;
    end
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned TOUT_W = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_push,
  input  logic [7:0]       rx_wdata,
  input  logic             rx_pop,
  output logic [7:0]       rx_rdata,
  output logic [LVL_W-1:0] rx_level,
  input  logic             rx_flush,
  input  logic             tx_push,
  input  logic [7:0]       tx_wdata,
  input  logic             tx_pop,
  output logic [7:0]       tx_rdata,
  output logic [LVL_W-1:0] tx_level,
  input  logic             tx_flush,
  input  logic             rx_parity_err,
  input  logic             rx_frame_err,
  input  logic             rx_break,
  input  logic             dsr_n,
  input  logic             cts_n,
  input  logic             bit_tick,
  input  logic [6:0]       rx_full_thr,
  input  logic [6:0]       tx_empty_thr,
  input  logic [6:0]       rts_thr,
  input  logic             rts_hw_en,
  input  logic [6:0]       tout_thr,
  input  logic             tout_en,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [8:0]       reg_wdata,
  output logic [8:0]       irq_raw,
  output logic [8:0]       irq_status,
  output logic             irq,
  output logic             rts_n
);
  // Named internal events
  logic     rx_full, rx_empty, rx_overflow, rx_accept;
  logic     dsr_q, cts_q, dsr_edge, cts_edge;
  logic     tout_fire, rts_stall;
  logic [7:0] rx_lvl8, tx_lvl8;
  irq_vec_t set_ev, clr_vec, irq_ena;

  sio_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .wdata(rx_wdata),
    .pop(rx_pop), .rdata(rx_rdata), .level(rx_level)
  );

  sio_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_rdata), .level(tx_level)
  );

  assign rx_lvl8     = 8'(rx_level);
  assign tx_lvl8     = 8'(tx_level);
  assign rx_full     = (rx_level == LVL_W'(DEPTH));
  assign rx_empty    = (rx_level == '0);
  assign rx_overflow = rx_push && rx_full && !rx_flush;
  assign rx_accept   = rx_push && !rx_full && !rx_flush;

  // Modem-line edge detection; lines idle high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsr_q <= 1'b1;
      cts_q <= 1'b1;
    end else begin
      dsr_q <= dsr_n;
      cts_q <= cts_n;
    end
  end
  assign dsr_edge = dsr_n ^ dsr_q;
  assign cts_edge = cts_n ^ cts_q;

  sio_idle_timer #(.CNT_W(TOUT_W), .THR_W(THR_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .restart(rx_accept),
    .idle_q(rx_empty), .en(tout_en), .thr(tout_thr), .fire(tout_fire)
  );

  always_comb begin
    set_ev              = '0;
    set_ev[IRQ_RXFULL]  = lvl_above(rx_lvl8, rx_full_thr);
    set_ev[IRQ_TXEMPTY] = lvl_below(tx_lvl8, tx_empty_thr);
    set_ev[IRQ_PARITY]  = rx_parity_err;
    set_ev[IRQ_FRAME]   = rx_frame_err;
    set_ev[IRQ_OVF]     = rx_overflow;
    set_ev[IRQ_DSR]     = dsr_edge;
    set_ev[IRQ_CTS]     = cts_edge;
    set_ev[IRQ_BREAK]   = rx_break;
    set_ev[IRQ_TOUT]    = tout_fire;
  end

  assign clr_vec = (reg_we && reg_sel) ? reg_wdata : '0;

  sio_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_vec(clr_vec),
    .ena_we(reg_we && !reg_sel), .ena_data(reg_wdata), .raw(irq_raw), .ena(irq_ena)
  );

  assign irq_status = irq_raw & irq_ena;
  assign irq        = |irq_status;

  // Registered RTS stall
  assign rts_stall = rts_hw_en && lvl_above(rx_lvl8, rts_thr);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n <= 1'b0;
    else        rts_n <= rts_stall;
  end
endmodule

// File: rtl/sio_irq_chk.sv
module sio_irq_chk
  import sio_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_push,
  input logic             rx_flush,
  input logic [LVL_W-1:0] rx_level,
  input logic [8:0]       irq_raw,
  input logic [8:0]       clr_vec,
  input logic [8:0]       set_ev,
  input logic             rts_hw_en,
  input logic [6:0]       rts_thr,
  input logic             rts_n,
  input logic             rx_parity_err,
  input logic [6:0]       rx_full_thr
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_level <= LVL_W'(DEPTH)); // R1
  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((~irq_raw & $past(irq_raw) & ~$past(clr_vec)) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (|set_ev) |=> ((irq_raw & $past(set_ev)) == $past(set_ev))); // R3
  AST_RXFULL_RAISE: assert property (@(posedge clk) disable iff (!rst_n) lvl_above(8'(rx_level), rx_full_thr) |=> irq_raw[IRQ_RXFULL]); // R4
  AST_RTS_STALL: assert property (@(posedge clk) disable iff (!rst_n) (rts_hw_en && lvl_above(8'(rx_level), rts_thr)) |=> rts_n); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (rx_push && !rx_flush && rx_level == LVL_W'(DEPTH)) |=> (irq_raw[IRQ_OVF] && rx_level == LVL_W'(DEPTH))); // R7
  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n) rx_parity_err |=> irq_raw[IRQ_PARITY]); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) rx_flush |=> (rx_level == '0)); // R11
endmodule

bind sio_irq_ctrl sio_irq_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_sio_irq_ctrl.sv
module tb_sio_irq_ctrl;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_push = 0, rx_pop = 0, rx_flush = 0, tx_push = 0, tx_pop = 0, tx_flush = 0;
  logic [7:0] rx_wdata = 0, tx_wdata = 0, rx_rdata, tx_rdata;
  logic [4:0] rx_level, tx_level;
  logic rx_parity_err = 0, rx_frame_err = 0, rx_break = 0, dsr_n = 1, cts_n = 1, bit_tick = 0;
  logic [6:0] rx_full_thr = 7'd127, tx_empty_thr = 7'd0, rts_thr = 7'd127, tout_thr = 7'd0;
  logic rts_hw_en = 0, tout_en = 0, reg_we = 0, reg_sel = 0;
  logic [8:0] reg_wdata = 0, irq_raw, irq_status;
  logic irq, rts_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_irq_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push = 1; rx_wdata = d; cyc(1); rx_push = 0;
  endtask
  task automatic push_tx(input logic [7:0] d);
    tx_push = 1; tx_wdata = d; cyc(1); tx_push = 0;
  endtask
  task automatic pop_rx(); rx_pop = 1; cyc(1); rx_pop = 0; endtask
  task automatic pop_tx(); tx_pop = 1; cyc(1); tx_pop = 0; endtask
  task automatic reg_wr(input logic sel, input logic [8:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d; cyc(1); reg_we = 0; reg_wdata = 0;
  endtask
  task automatic flush_all();
    rx_flush = 1; tx_flush = 1; cyc(1); rx_flush = 0; tx_flush = 0;
    cyc(1); reg_wr(1'b1, 9'h1FF); cyc(1);
  endtask
  task automatic tick(); bit_tick = 1; cyc(1); bit_tick = 0; endtask

  task automatic t_reset();
    chk("R1 reset rx level", rx_level, 0);
    chk("R1 reset tx level", tx_level, 0);
    chk("R2 reset raw", irq_raw, 0);
    chk("R2 reset irq", irq, 0);
    chk("R6 reset rts_n", rts_n, 0);
  endtask

  task automatic t_order();
    pop_rx(); chk("R1 pop empty ignored", rx_level, 0);
    push_rx(8'hA1); push_rx(8'hB2); push_rx(8'hC3);
    chk("R1 rx level", rx_level, 3);
    chk("R1 rx first", rx_rdata, 8'hA1); pop_rx();
    chk("R1 rx second", rx_rdata, 8'hB2); pop_rx();
    chk("R1 rx third", rx_rdata, 8'hC3); pop_rx();
    chk("R1 rx drained", rx_level, 0);
    push_tx(8'h5A); push_tx(8'h3C);
    chk("R1 tx first", tx_rdata, 8'h5A); pop_tx();
    chk("R1 tx second", tx_rdata, 8'h3C);
    flush_all();
  endtask

  task automatic t_rxfull();
    rx_full_thr = 7'd2;
    push_rx(8'h01); push_rx(8'h02); cyc(2);
    chk("R4 at threshold no flag", irq_raw[0], 0);
    push_rx(8'h03); cyc(1);
    chk("R4 above threshold", irq_raw[0], 1);
    pop_rx(); cyc(1); reg_wr(1'b1, 9'h001); cyc(1);
    chk("R4 cleared at threshold", irq_raw[0], 0);
    rx_full_thr = 7'd127; flush_all();
  endtask

  task automatic t_txempty();
    tx_empty_thr = 7'd3; cyc(2);
    chk("R5 empty below threshold", irq_raw[1], 1);
    push_tx(8'h10); push_tx(8'h11); push_tx(8'h12); cyc(1);
    reg_wr(1'b1, 9'h002); cyc(1);
    chk("R5 at threshold no flag", irq_raw[1], 0);
    pop_tx(); cyc(1);
    chk("R5 drained below threshold", irq_raw[1], 1);
    tx_empty_thr = 7'd0; flush_all();
  endtask

  task automatic t_rts();
    rts_hw_en = 1; rts_thr = 7'd1;
    push_rx(8'h21); cyc(2);
    chk("R6 at watermark", rts_n, 0);
    push_rx(8'h22); cyc(1);
    chk("R6 above watermark", rts_n, 1);
    rts_hw_en = 0; cyc(1);
    chk("R6 disabled", rts_n, 0);
    rts_thr = 7'd127; flush_all();
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i + 8'h40));
    cyc(1);
    chk("R7 full no overflow", irq_raw[4], 0);
    chk("R7 full level", rx_level, DEPTH);
    push_rx(8'hEE); cyc(1);
    chk("R7 overflow flag", irq_raw[4], 1);
    chk("R7 level held", rx_level, DEPTH);
    chk("R7 head intact", rx_rdata, 8'h40);
    flush_all();
  endtask

  task automatic t_errors();
    rx_parity_err = 1; cyc(1); rx_parity_err = 0;
    rx_frame_err = 1; cyc(1); rx_frame_err = 0;
    rx_break = 1; cyc(1); rx_break = 0;
    chk("R8 error bits", irq_raw, 9'h08C);
    reg_wr(1'b1, 9'h1FF); cyc(1);
  endtask

  task automatic t_modem();
    dsr_n = 0; cyc(1);
    chk("R9 dsr fall", irq_raw, 9'h020);
    reg_wr(1'b1, 9'h1FF);
    cts_n = 0; cyc(1); reg_wr(1'b1, 9'h1FF); cyc(1);
    chk("R9 cleared between edges", irq_raw, 0);
    cts_n = 1; cyc(1);
    chk("R9 cts rise", irq_raw, 9'h040);
    dsr_n = 1; cyc(1); reg_wr(1'b1, 9'h1FF); cyc(1);
  endtask

  task automatic t_timeout();
    tout_en = 1; tout_thr = 7'd2;
    tick(); tick(); tick(); tick();
    chk("R10 empty queue no timeout", irq_raw[8], 0);
    push_rx(8'h77);
    tick(); tick();
    chk("R10 before threshold", irq_raw[8], 0);
    tick();
    chk("R10 fires", irq_raw[8], 1);
    reg_wr(1'b1, 9'h100); tick(); tick(); cyc(1);
    chk("R10 once per idle spell", irq_raw[8], 0);
    push_rx(8'h78); tick(); tick(); push_rx(8'h79); tick(); tick();
    chk("R10 restart on byte", irq_raw[8], 0);
    tick();
    chk("R10 fires after restart", irq_raw[8], 1);
    tout_en = 0; flush_all();
  endtask

  task automatic t_mask();
    reg_wr(1'b0, 9'h004);
    rx_parity_err = 1; rx_frame_err = 1; cyc(1); rx_parity_err = 0; rx_frame_err = 0;
    chk("R2 raw both", irq_raw, 9'h00C);
    chk("R2 status masked", irq_status, 9'h004);
    chk("R2 irq", irq, 1);
    reg_wr(1'b1, 9'h004); cyc(1);
    chk("R2 irq after clear", irq, 0);
    reg_wr(1'b0, 9'h000); reg_wr(1'b1, 9'h1FF); cyc(1);
  endtask

  task automatic t_setclr();
    rx_parity_err = 1; cyc(1); rx_parity_err = 0;
    rx_parity_err = 1; reg_we = 1; reg_sel = 1; reg_wdata = 9'h004;
    cyc(1);
    rx_parity_err = 0; reg_we = 0; reg_wdata = 0;
    chk("R3 set wins over clear", irq_raw[2], 1);
    reg_wr(1'b1, 9'h004);
    chk("R3 clear alone", irq_raw[2], 0);
  endtask

  task automatic t_flush();
    push_rx(8'h31); push_rx(8'h32); push_tx(8'h41); push_tx(8'h42);
    rx_flush = 1; rx_push = 1; rx_wdata = 8'h99; cyc(1); rx_flush = 0; rx_push = 0;
    chk("R11 rx emptied", rx_level, 0);
    chk("R11 tx untouched", tx_level, 2);
    tx_flush = 1; cyc(1); tx_flush = 0;
    chk("R11 tx emptied", tx_level, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_order();
    t_rxfull();
    t_txempty();
    t_rts();
    t_overflow();
    t_errors();
    t_modem();
    t_timeout();
    t_mask();
    t_setclr();
    t_flush();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule